// File: doc/BRIEF.md
# Converter Bus Control and Readout Interface

This block sits between a processor bus and the sequencer of a 12-bit successive-approximation converter. It samples five control pins into the system clock: chip enable (high-true), chip select (low-true), read/convert, byte address and word/byte select. From them it derives a one-cycle conversion start pulse and a latched length flag for the sequencer. It also drives the result onto the bus through two output lanes, each with its own enable. A busy flag from the sequencer gates both starts and reads.

A start fires when enable is high, select is low and read/convert is low, and the last of the three to arrive triggers it. Results can be read as a whole word or as two left-justified bytes on a shared 8-bit bus. A stand-alone setup ties enable high, select low and the word select high, so that read/convert is the only line that moves. Tri-state pins are modelled as a data vector plus an enable for the upper lane (bits 11:4) and an enable for the lower lane (bits 3:0).

Top module: `adc_bus_ctrl`

## Requirements
- R1: start_o is high for exactly one cycle when ce_i=1, cs_n_i=0 and rc_i=0 first hold together. It rises on the third rising clock edge after the completing pin change (SYNC_STAGES=2).
- R2: The start fires no matter which of ce_i, cs_n_i or rc_i completes the condition last, or if all three change together.
- R3: While busy_i is high, a new start condition produces no start_o pulse.
- R4: Every new start condition, including one while busy_i is high, loads a0_i into len_short_o (1 = short 8-bit conversion, 0 = full 12-bit conversion).
- R5: Reads need rc_i=1, busy_i=0, ce_i=1 and cs_n_i=0 together. Otherwise oe_upper_o and oe_lower_o are 0 and data_o is all zeros.
- R6: In word mode (wsel_i=1), a read sets both lane enables and data_o equals result_i, whatever a0_i is.
- R7: In byte mode (wsel_i=0) with a0_i=0, a read sets only oe_upper_o, and data_o[11:4]=result_i[11:4] with data_o[3:0]=0.
- R8: In byte mode with a0_i=1, a read sets only oe_upper_o, with data_o[11:4]={result_i[3:0],4'b0000}. oe_lower_o is never set without oe_upper_o, so the two bytes never drive the shared bus lines at the same moment.
- R9: In stand-alone use (ce_i=1, cs_n_i=0, wsel_i=1 tied), a falling rc_i starts a conversion. The previous result is readable whenever rc_i is high and busy_i is low.
- R10: While rst_i is high, start_o, len_short_o, both lane enables and data_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Chip enable pin, active high, asynchronous |
| cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| rc_i | input | 1 | Read (1) / convert (0) pin, asynchronous |
| a0_i | input | 1 | Byte address and short-length pin, asynchronous |
| wsel_i | input | 1 | Word (1) / byte (0) read select, asynchronous |
| busy_i | input | 1 | Conversion in progress, from the sequencer |
| result_i | input | RES_W | Last conversion result from the sequencer |
| start_o | output | 1 | One-cycle conversion start pulse |
| len_short_o | output | 1 | Latched length: 1 = 8-bit, 0 = 12-bit |
| data_o | output | RES_W | Output data value for the pins |
| oe_upper_o | output | 1 | Drive enable for data_o[11:4] |
| oe_lower_o | output | 1 | Drive enable for data_o[3:0] |

## Verification
The bench completes the start condition with each of the three pins in turn. A design that edge-detects only one pin would miss two of those cases. It repeats start transitions while busy is high: a design without the lockout would restart the sequencer, and one that gates the length latch with busy would keep the old length. All 64 combinations of the read-side pins and busy are swept against the enable rule, which exposes a missing term in the read gate or a lower lane that stays on in byte mode. The padded low byte and the ignored byte address in word mode are also checked, which catches a swapped or unpadded byte mux.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  // Sampled control pins in one bundle
  typedef struct packed {
    logic ce;
    logic cs_n;
    logic rc;
    logic a0;
    logic wsel;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  // Inactive pin levels loaded by reset so no start appears after reset
  localparam pins_t PINS_IDLE = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0, wsel: 1'b0};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stg[s] <= RST_VAL;
          else       stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stg[s] <= RST_VAL;
          else       stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/start_ctl.sv
module start_ctl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ce,
  input  logic cs_n,
  input  logic rc,
  input  logic a0,
  input  logic busy_i,
  output logic start_o,
  output logic len_short_o
);
  logic cond, cond_q, cond_rise;

  // Whichever pin completes the condition, the combined term rises once
  assign cond      = ce & ~cs_n & ~rc;
  assign cond_rise = cond & ~cond_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cond_q      <= 1'b0;
      start_o     <= 1'b0;
      len_short_o <= 1'b0;
    end else begin
      cond_q  <= cond;
      start_o <= cond_rise & ~busy_i;
      // Length follows every start transition, busy or not
      if (cond_rise) len_short_o <= a0;
    end
  end
endmodule

// File: rtl/read_mux.sv
module read_mux #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  adc_bus_pkg::pins_t pins_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] data_o,
  output logic             oe_upper_o,
  output logic             oe_lower_o
);
  localparam int LO_W  = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  logic              rd_en;
  logic [BYTE_W-1:0] hi_byte, lo_byte, sel_byte;

  assign rd_en    = pins_i.rc & ~busy_i & pins_i.ce & ~pins_i.cs_n;
  assign hi_byte  = result_i[RES_W-1:LO_W];
  assign lo_byte  = {result_i[LO_W-1:0], {PAD_W{1'b0}}};
  assign sel_byte = pins_i.a0 ? lo_byte : hi_byte;

  always_ff @(posedge clk_i) begin
    if (rst_i || !rd_en) begin
      data_o     <= '0;
      oe_upper_o <= 1'b0;
      oe_lower_o <= 1'b0;
    end else if (pins_i.wsel) begin
      data_o     <= result_i;
      oe_upper_o <= 1'b1;
      oe_lower_o <= 1'b1;
    end else begin
      data_o     <= {sel_byte, {LO_W{1'b0}}};
      oe_upper_o <= 1'b1;
      oe_lower_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int RES_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ce_i,
  input  logic             cs_n_i,
  input  logic             rc_i,
  input  logic             a0_i,
  input  logic             wsel_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic             start_o,
  output logic             len_short_o,
  output logic [RES_W-1:0] data_o,
  output logic             oe_upper_o,
  output logic             oe_lower_o
);
  import adc_bus_pkg::*;

  pins_t pins_raw, pins_s;

  assign pins_raw = '{ce: ce_i, cs_n: cs_n_i, rc: rc_i, a0: a0_i, wsel: wsel_i};

  pin_sync #(
    .W      (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  start_ctl u_start (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ce         (pins_s.ce),
    .cs_n       (pins_s.cs_n),
    .rc         (pins_s.rc),
    .a0         (pins_s.a0),
    .busy_i     (busy_i),
    .start_o    (start_o),
    .len_short_o(len_short_o)
  );

  read_mux #(
    .RES_W (RES_W),
    .BYTE_W(BYTE_W)
  ) u_read (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pins_i    (pins_s),
    .busy_i    (busy_i),
    .result_i  (result_i),
    .data_o    (data_o),
    .oe_upper_o(oe_upper_o),
    .oe_lower_o(oe_lower_o)
  );
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             busy_i,
  input logic             start_o,
  input logic [RES_W-1:0] data_o,
  input logic             oe_upper_o,
  input logic             oe_lower_o
);
  localparam int LO_W = RES_W - BYTE_W;

  // R1
  start_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> !start_o);

  // R3
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(busy_i) |-> !start_o);

  // R5
  no_drive_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(busy_i) |-> !(oe_upper_o || oe_lower_o));

  // R5
  quiet_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_upper_o |-> (data_o == '0));

  // R8
  lane_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    oe_lower_o |-> oe_upper_o);

  // R8
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_lower_o |-> (data_o[LO_W-1:0] == '0));
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .busy_i    (busy_i),
  .start_o   (start_o),
  .data_o    (data_o),
  .oe_upper_o(oe_upper_o),
  .oe_lower_o(oe_lower_o)
);

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
  localparam int CLK_NS = 4;
  localparam int RES_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, cs_n = 1'b1, rc = 1'b1, a0 = 1'b0, wsel = 1'b0, busy = 1'b0;
  logic [RES_W-1:0] result = 12'hA5C;
  logic start, len_short, oe_u, oe_l;
  logic [RES_W-1:0] data;

  int checks = 0;
  int fails  = 0;
  int starts = 0;

  always #(CLK_NS/2) clk = ~clk;

  adc_bus_ctrl i_adc_bus_ctrl (
    .clk_i(clk), .rst_i(rst), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc),
    .a0_i(a0), .wsel_i(wsel), .busy_i(busy), .result_i(result),
    .start_o(start), .len_short_o(len_short), .data_o(data),
    .oe_upper_o(oe_u), .oe_lower_o(oe_l)
  );

  always @(negedge clk) if (!rst && start) starts++;

  // {ce, cs_n, rc, a0, wsel, busy, exp_oe_u, exp_oe_l, exp_data}
  localparam logic [19:0] TBL [8] = '{
    {8'b1010_1011, 12'hA5C},  // R6 word, a0=0
    {8'b1011_1011, 12'hA5C},  // R6 word, a0 ignored
    {8'b1010_0010, 12'hA50},  // R7 high byte
    {8'b1011_0010, 12'hC00},  // R8 low byte padded
    {8'b1010_1100, 12'h000},  // R5 busy blocks read
    {8'b0010_1000, 12'h000},  // R5 chip enable low
    {8'b1110_1000, 12'h000},  // R5 chip select high
    {8'b1000_1000, 12'h000}   // R5 convert level
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce = 1'b0; cs_n = 1'b1; rc = 1'b1; busy = 1'b0;
    settle(5);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_NS * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n0;
    // R10 reset state
    settle(4);
    check(!start && !len_short && !oe_u && !oe_l && data == 0, "R10 reset",
          {start, len_short, oe_u, oe_l, data}, 0);
    rst = 1'b0;
    settle(4);

    // Table walk for read lanes
    for (int i = 0; i < 8; i++) begin
      {ce, cs_n, rc, a0, wsel, busy} = TBL[i][19:14];
      settle(5);
      check({oe_u, oe_l, data} == TBL[i][13:0], $sformatf("R5/R6/R7/R8 table %0d", i),
            {oe_u, oe_l, data}, TBL[i][13:0]);
    end

    // Exhaustive enable rule, R5 and R8
    for (int k = 0; k < 64; k++) begin
      logic rd;
      {ce, cs_n, rc, a0, wsel, busy} = k[5:0];
      settle(4);
      rd = rc & ~busy & ce & ~cs_n;
      check(oe_u == rd && oe_l == (rd & wsel), $sformatf("R5 sweep %0d", k),
            {oe_u, oe_l}, {rd, rd & wsel});
    end
    idle();

    // R1 latency and single-cycle pulse, all three at once (R2)
    n0 = starts;
    ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
    settle(2);
    check(start == 1'b0, "R1 no early start", start, 0);
    settle(1);
    check(start == 1'b1, "R1 start on third edge", start, 1);
    settle(1);
    check(start == 1'b0, "R1 pulse one cycle", start, 0);
    settle(3);
    check(starts - n0 == 1, "R2 simultaneous", starts - n0, 1);
    idle();

    // R2 chip enable last
    cs_n = 1'b0; rc = 1'b0; settle(5);
    n0 = starts; ce = 1'b1; settle(6);
    check(starts - n0 == 1, "R2 enable last", starts - n0, 1);
    idle();
    // R2 chip select last
    ce = 1'b1; rc = 1'b0; settle(5);
    n0 = starts; cs_n = 1'b0; settle(6);
    check(starts - n0 == 1, "R2 select last", starts - n0, 1);
    idle();
    // R2 read/convert last
    ce = 1'b1; cs_n = 1'b0; settle(5);
    n0 = starts; rc = 1'b0; settle(6);
    check(starts - n0 == 1, "R2 convert last", starts - n0, 1);
    idle();

    // R3 lockout while busy
    busy = 1'b1; settle(2);
    n0 = starts; ce = 1'b1; cs_n = 1'b0; rc = 1'b0; settle(6);
    check(starts - n0 == 0, "R3 busy lockout", starts - n0, 0);
    idle();

    // R4 length latch, including re-latch during busy
    a0 = 1'b1; n0 = starts;
    ce = 1'b1; cs_n = 1'b0; rc = 1'b0; settle(6);
    check(len_short == 1'b1, "R4 short length", len_short, 1);
    check(starts - n0 == 1, "R4 start issued", starts - n0, 1);
    busy = 1'b1; rc = 1'b1; settle(5);
    a0 = 1'b0; n0 = starts; rc = 1'b0; settle(6);
    check(len_short == 1'b0, "R4 relatch during busy", len_short, 0);
    check(starts - n0 == 0, "R3 no restart", starts - n0, 0);
    rc = 1'b1; settle(5);
    a0 = 1'b1; rc = 1'b0; settle(6);
    check(len_short == 1'b1, "R4 relatch back", len_short, 1);
    idle();

    // R9 stand-alone: only rc moves
    ce = 1'b1; cs_n = 1'b0; wsel = 1'b1; a0 = 1'b0; result = 12'h3E7;
    rc = 1'b1; settle(5);
    check(oe_u && oe_l && data == 12'h3E7, "R9 read while high", data, 12'h3E7);
    n0 = starts; rc = 1'b0; settle(6);
    check(starts - n0 == 1, "R9 falling edge start", starts - n0, 1);
    busy = 1'b1; rc = 1'b1; settle(5);
    check(!oe_u && !oe_l && data == 0, "R9 hidden while busy", data, 0);
    n0 = starts; rc = 1'b0; settle(3); rc = 1'b1; settle(5);
    check(starts - n0 == 0, "R9 pulse ignored busy", starts - n0, 0);
    busy = 1'b0; settle(3);
    check(oe_u && oe_l && data == 12'h3E7, "R9 readable after busy", data, 12'h3E7);

    // R10 reset clears a live read
    rst = 1'b1; settle(2);
    check(!oe_u && !oe_l && data == 0 && !len_short, "R10 reset mid read", data, 0);

    summary();
    $finish;
  end
endmodule